// File: doc/BRIEF.md
# Multiplexed Burst Local-Bus Master

This block is the master side of a 32-bit local bus on which address and data share the same wires. An internal client hands it a transaction: a read, a write or an atomic read-modify-write. The transaction comes with a word address, a burst length of one to four words and, for writes, the burst's write words. The master then runs the bus sequence. First comes one address cycle that carries the word address and a burst-size code. Data cycles follow, one per word, and each one lasts until the target raises READY. The shared lines are modelled as an output value plus an output enable, so a pad ring or a test bench can resolve them.

An address/data status strobe marks the address cycle. It is pulsed again in every data cycle that follows a word the target accepted, so the target can pace the burst through READY alone. An active-low latch strobe accompanies the address. A write/read flag and a transfer-direction flag are set with the address and held through the data. An active-low data enable covers the data and wait cycles.

For a read-modify-write, the master first waits while another agent holds the open-drain lock line. It then pulls the line low from the address cycle of the read burst until the address cycle of the write burst. Read words return to the client one per accepted word, and the final word carries a last flag.

Top module: `lbus_master`

## Requirements
- R1: In the address cycle the master drives the shared bus, which carries the word address on bits 31:2 and the burst code on bits 1:0 (0 = one word, 1 = two, 2 = three, 3 = four). The latch strobe and the status strobe are both low and the data enable is high.
- R2: The latch strobe is low for exactly one cycle per address phase and is high in every data and wait cycle.
- R3: The status strobe is high in the first data cycle after an address cycle. It is low in any data cycle whose preceding cycle was a data cycle with READY high.
- R4: A data cycle with READY low is repeated as a wait state. The next cycle is still a data cycle with the status strobe high, and the write word on the bus is unchanged.
- R5: The write/read flag and the direction flag are 1 for a write and 0 for a read. They are set in the address cycle and do not change while the data enable is low.
- R6: The data enable is low only in data and wait cycles, and the direction flag does not change in the cycle the data enable falls.
- R7: In a write burst, data beat k drives write word k (bits k*32+31:k*32 of the request write vector) onto the bus. In a read burst the master floats the bus during data cycles.
- R8: Each read word accepted with READY high appears on the read-return port one cycle later, with the valid flag set. The last-word flag is set only on the final word of the burst.
- R9: A burst ends after exactly length+1 accepted words. The following cycle is an idle cycle with the bus floated, or else the write address cycle of a read-modify-write.
- R10: Request codes are 0 = read, 1 = write, 2 = read-modify-write, and 3 = read. A read-modify-write waits, with no address cycle, while the lock line is held low by another agent. It pulls the line low from its read address cycle on and releases it in the address cycle of its write burst, which uses the same address and length.
- R11: The request ready flag is high only while the master is idle. An accepted request starts its address cycle in the next cycle, unless it is waiting for the lock.
- R12: While reset is high and after it, the master is idle, the bus is floated, the latch, status and data-enable strobes are high and the lock line is released. This holds even when reset arrives in the middle of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Master idle, request accepted when valid |
| req_op | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 read |
| req_addr | input | 30 | Word address |
| req_len | input | 2 | Burst length minus one |
| req_wdata | input | 128 | Write words, word k in bits k*32+31:k*32 |
| rd_valid | output | 1 | Read word returned |
| rd_data | output | 32 | Returned read word |
| rd_last | output | 1 | Final word of the read burst |
| bus_ad_o | output | 32 | Shared address/data value driven |
| bus_ad_oe | output | 1 | Drive enable for the shared lines |
| bus_ad_i | input | 32 | Shared lines as seen by the master |
| bus_latch_n | output | 1 | Address latch strobe, active low |
| bus_stat_n | output | 1 | Address/data status strobe, active low |
| bus_wr | output | 1 | 1 for write, 0 for read |
| bus_dir | output | 1 | Transfer direction, 1 = master transmits |
| bus_den_n | output | 1 | Data enable, active low |
| bus_rdy | input | 1 | Target READY |
| bus_lock_n_i | input | 1 | Lock line level, low when held |
| bus_lock_drive | output | 1 | 1 pulls the open-drain lock line low |

## Verification
The bench builds the master with its default parameters: a 32-bit bus and up to four words per burst. All four burst codes on the low address bits and every beat position of the write vector are therefore within reach. A 64-word memory model behind the bus feeds reads and absorbs writes, while READY is drawn at random so that wait states land on the first, middle and last beats. Directed cases cover single-word and unstalled four-word bursts, a read-modify-write held off by a foreign lock holder, the direct turn from read burst to write burst, and a reset taken in the middle of a stalled write.

// File: rtl/lbus_pkg.sv
package lbus_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_RMW   = 2'd2
  } lbus_op_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_LWAIT = 2'd1,
    S_ADDR  = 2'd2,
    S_DATA  = 2'd3
  } lbus_st_e;
endpackage

// File: rtl/lbus_req_hold.sv
module lbus_req_hold #(
  parameter int DATA_W    = 32,
  parameter int MAX_BEATS = 4,
  parameter int LEN_W     = 2,
  parameter int ADDR_W    = 30
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load,
  input  logic [ADDR_W-1:0]           in_addr,
  input  logic [LEN_W-1:0]            in_len,
  input  logic [MAX_BEATS*DATA_W-1:0] in_wdata,
  input  logic [LEN_W-1:0]            idx,
  output logic [ADDR_W-1:0]           v_addr,
  output logic [LEN_W-1:0]            v_len,
  output logic [DATA_W-1:0]           v_word
);
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [DATA_W-1:0] in_w    [MAX_BEATS];
  logic [DATA_W-1:0] words_q [MAX_BEATS];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      len_q  <= '0;
    end else if (load) begin
      addr_q <= in_addr;
      len_q  <= in_len;
    end
  end

  // write words: no reset, plain register file
  for (genvar g = 0; g < MAX_BEATS; g++) begin : g_word
    assign in_w[g] = in_wdata[g*DATA_W +: DATA_W];
    always_ff @(posedge clk) begin
      if (load) words_q[g] <= in_w[g];
    end
  end

  // view: the incoming request in the accept cycle, stored copy afterwards
  assign v_addr = load ? in_addr : addr_q;
  assign v_len  = load ? in_len  : len_q;
  assign v_word = load ? in_w[idx] : words_q[idx];
endmodule

// File: rtl/lbus_lock_ctl.sv
module lbus_lock_ctl (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic lock_n_i,
  output logic pull,
  output logic busy
);
  always_ff @(posedge clk) begin
    if (rst)      pull <= 1'b0;
    else if (set) pull <= 1'b1;
    else if (clr) pull <= 1'b0;
  end

  // line held low by somebody other than this master
  assign busy = !lock_n_i && !pull;

  p_set_clr_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(set && clr));
  p_set_when_free_r10: assert property (@(posedge clk) disable iff (rst)
    set |-> !busy);
  p_pull_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (pull && !clr) |=> pull);
endmodule

// File: rtl/lbus_seq.sv
module lbus_seq
  import lbus_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MAX_BEATS = 4,
  parameter int LEN_W     = 2,
  parameter int ADDR_W    = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  output logic              req_ready,
  output logic              load,
  input  logic [ADDR_W-1:0] v_addr,
  input  logic [LEN_W-1:0]  v_len,
  input  logic [DATA_W-1:0] v_word,
  output logic [LEN_W-1:0]  beat_sel,
  input  logic              rdy,
  input  logic [DATA_W-1:0] ad_i,
  input  logic              lock_busy,
  input  logic              lock_pull,
  output logic              lock_set,
  output logic              lock_clr,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  output logic              latch_n,
  output logic              stat_n,
  output logic              wr,
  output logic              dir,
  output logic              den_n,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last
);
  lbus_st_e         st_q, st_d;
  logic [LEN_W-1:0] beat_q, beat_d;
  logic             wph_q, wph_d;
  logic             rmw_q, rmw_d;
  logic             last_beat;
  logic             op_wr, op_rmw;

  assign req_ready = (st_q == S_IDLE);
  assign load      = req_valid && req_ready;
  assign beat_sel  = beat_d;
  assign last_beat = (beat_q == v_len);
  assign op_wr     = (req_op == OP_WRITE);
  assign op_rmw    = (req_op == OP_RMW);

  always_comb begin
    st_d     = st_q;
    beat_d   = beat_q;
    wph_d    = wph_q;
    rmw_d    = rmw_q;
    lock_set = 1'b0;
    lock_clr = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (load) begin
          rmw_d  = op_rmw;
          wph_d  = op_wr;
          beat_d = '0;
          if (op_rmw && lock_busy) begin
            st_d = S_LWAIT;
          end else begin
            st_d     = S_ADDR;
            lock_set = op_rmw;
          end
        end
      end
      S_LWAIT: begin
        if (!lock_busy) begin
          st_d     = S_ADDR;
          lock_set = 1'b1;
        end
      end
      S_ADDR: st_d = S_DATA;
      S_DATA: begin
        if (rdy) begin
          if (last_beat) begin
            if (rmw_q && !wph_q) begin
              st_d     = S_ADDR;
              wph_d    = 1'b1;
              beat_d   = '0;
              lock_clr = 1'b1;
            end else begin
              st_d = S_IDLE;
            end
          end else begin
            beat_d = beat_q + LEN_W'(1);
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  // all bus outputs registered from the next-state view
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_IDLE;
      beat_q   <= '0;
      wph_q    <= 1'b0;
      rmw_q    <= 1'b0;
      ad_o     <= '0;
      ad_oe    <= 1'b0;
      latch_n  <= 1'b1;
      stat_n   <= 1'b1;
      den_n    <= 1'b1;
      wr       <= 1'b0;
      dir      <= 1'b0;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
    end else begin
      st_q    <= st_d;
      beat_q  <= beat_d;
      wph_q   <= wph_d;
      rmw_q   <= rmw_d;
      ad_oe   <= (st_d == S_ADDR) || ((st_d == S_DATA) && wph_d);
      if (st_d == S_ADDR)                ad_o <= {v_addr, v_len};
      else if ((st_d == S_DATA) && wph_d) ad_o <= v_word;
      else                               ad_o <= '0;
      latch_n <= !(st_d == S_ADDR);
      stat_n  <= !((st_d == S_ADDR) ||
                   ((st_d == S_DATA) && (st_q == S_DATA) && rdy));
      den_n   <= !(st_d == S_DATA);
      if (st_d == S_ADDR) begin
        wr  <= wph_d;
        dir <= wph_d;
      end
      rd_valid <= (st_q == S_DATA) && !wph_q && rdy;
      rd_last  <= (st_q == S_DATA) && !wph_q && rdy && last_beat;
    end
  end

  always_ff @(posedge clk) begin
    if ((st_q == S_DATA) && !wph_q && rdy) rd_data <= ad_i;
  end

  p_addr_cycle_r1: assert property (@(posedge clk) disable iff (rst)
    !latch_n |-> (!stat_n && ad_oe && den_n));
  p_latch_one_r2: assert property (@(posedge clk) disable iff (rst)
    !latch_n |=> latch_n);
  p_first_data_r3: assert property (@(posedge clk) disable iff (rst)
    !latch_n |=> (stat_n && !den_n));
  p_restat_r3: assert property (@(posedge clk) disable iff (rst)
    (!den_n && rdy && !last_beat) |=> (!den_n && !stat_n));
  p_wait_r4: assert property (@(posedge clk) disable iff (rst)
    (!den_n && !rdy) |=> (!den_n && stat_n && $stable(ad_o)));
  p_dir_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (!den_n && $past(!den_n)) |-> ($stable(dir) && $stable(wr)));
  p_dir_setup_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(den_n) |-> $stable(dir));
  p_read_float_r7: assert property (@(posedge clk) disable iff (rst)
    (!den_n && !wr) |-> !ad_oe);
  p_last_valid_r8: assert property (@(posedge clk) disable iff (rst)
    rd_last |-> rd_valid);
  p_idle_unlocked_r10: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !lock_pull);
  p_ready_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (den_n && latch_n && !ad_oe));
endmodule

// File: rtl/lbus_master.sv
module lbus_master #(
  parameter int DATA_W    = 32,
  parameter int MAX_BEATS = 4,
  parameter int LEN_W     = $clog2(MAX_BEATS),
  parameter int ADDR_W    = DATA_W - LEN_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [1:0]                  req_op,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [LEN_W-1:0]            req_len,
  input  logic [MAX_BEATS*DATA_W-1:0] req_wdata,
  output logic                        rd_valid,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        rd_last,
  output logic [DATA_W-1:0]           bus_ad_o,
  output logic                        bus_ad_oe,
  input  logic [DATA_W-1:0]           bus_ad_i,
  output logic                        bus_latch_n,
  output logic                        bus_stat_n,
  output logic                        bus_wr,
  output logic                        bus_dir,
  output logic                        bus_den_n,
  input  logic                        bus_rdy,
  input  logic                        bus_lock_n_i,
  output logic                        bus_lock_drive
);
  logic              load;
  logic [ADDR_W-1:0] v_addr;
  logic [LEN_W-1:0]  v_len;
  logic [DATA_W-1:0] v_word;
  logic [LEN_W-1:0]  beat_sel;
  logic              lock_busy, lock_set, lock_clr;

  lbus_req_hold #(
    .DATA_W(DATA_W), .MAX_BEATS(MAX_BEATS), .LEN_W(LEN_W), .ADDR_W(ADDR_W)
  ) u_hold (
    .clk(clk), .rst(rst), .load(load),
    .in_addr(req_addr), .in_len(req_len), .in_wdata(req_wdata),
    .idx(beat_sel), .v_addr(v_addr), .v_len(v_len), .v_word(v_word)
  );

  lbus_lock_ctl u_lock (
    .clk(clk), .rst(rst), .set(lock_set), .clr(lock_clr),
    .lock_n_i(bus_lock_n_i), .pull(bus_lock_drive), .busy(lock_busy)
  );

  lbus_seq #(
    .DATA_W(DATA_W), .MAX_BEATS(MAX_BEATS), .LEN_W(LEN_W), .ADDR_W(ADDR_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_op(req_op), .req_ready(req_ready), .load(load),
    .v_addr(v_addr), .v_len(v_len), .v_word(v_word), .beat_sel(beat_sel),
    .rdy(bus_rdy), .ad_i(bus_ad_i),
    .lock_busy(lock_busy), .lock_pull(bus_lock_drive),
    .lock_set(lock_set), .lock_clr(lock_clr),
    .ad_o(bus_ad_o), .ad_oe(bus_ad_oe), .latch_n(bus_latch_n),
    .stat_n(bus_stat_n), .wr(bus_wr), .dir(bus_dir), .den_n(bus_den_n),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last)
  );
endmodule

// File: tb/tb_lbus_master.sv
module tb_lbus_master;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [1:0]   req_op = 2'd0;
  logic [29:0]  req_addr = '0;
  logic [1:0]   req_len = '0;
  logic [127:0] req_wdata = '0;
  logic         rd_valid;
  logic [31:0]  rd_data;
  logic         rd_last;
  logic [31:0]  bus_ad_o;
  logic         bus_ad_oe;
  logic [31:0]  bus_ad_i = '0;
  logic         bus_latch_n, bus_stat_n, bus_wr, bus_dir, bus_den_n;
  logic         bus_rdy = 1'b0;
  logic         other_lock = 1'b0;
  logic         bus_lock_n_i;
  logic         bus_lock_drive;

  int total = 0;
  int bad   = 0;
  logic [31:0] mem [64];

  assign bus_lock_n_i = ~(other_lock | bus_lock_drive);

  always #(CLK_PERIOD/2) clk = ~clk;

  lbus_master dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_last(rd_last), .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe),
    .bus_ad_i(bus_ad_i), .bus_latch_n(bus_latch_n), .bus_stat_n(bus_stat_n),
    .bus_wr(bus_wr), .bus_dir(bus_dir), .bus_den_n(bus_den_n),
    .bus_rdy(bus_rdy), .bus_lock_n_i(bus_lock_n_i),
    .bus_lock_drive(bus_lock_drive)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] widx(input logic [29:0] a, input int k);
    return a[5:0] + 6'(k);
  endfunction

  task automatic chk_idle_bus(input string req);
    chk(bus_ad_oe == 1'b0, req, {31'd0, bus_ad_oe}, 32'd0);
    chk(bus_latch_n && bus_stat_n && bus_den_n, req,
        {29'd0, bus_latch_n, bus_stat_n, bus_den_n}, 32'd7);
    chk(bus_lock_drive == 1'b0, req, {31'd0, bus_lock_drive}, 32'd0);
  endtask

  // called just after a falling edge; returns just after a falling edge
  // rmode: 0 random READY, 1 READY always high
  task automatic run_txn(input logic [1:0] op, input logic [29:0] addr,
                         input logic [1:0] len, input int lock_hold,
                         input int rmode);
    logic [31:0] w [4];
    int          phases;
    bit          is_w, first, prev_rdy, r, pend, pend_last;
    logic [31:0] pend_data;
    logic [5:0]  ix;
    for (int k = 0; k < 4; k++) w[k] = $urandom;
    chk(req_ready == 1'b1, "R11 ready when idle", {31'd0, req_ready}, 32'd1);
    req_valid  = 1'b1;
    req_op     = op;
    req_addr   = addr;
    req_len    = len;
    req_wdata  = {w[3], w[2], w[1], w[0]};
    other_lock = (lock_hold > 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11 busy after accept", {31'd0, req_ready}, 32'd0);
    for (int i = 0; i < lock_hold; i++) begin
      chk(bus_latch_n == 1'b1 && bus_lock_drive == 1'b0,
          "R10 waits on foreign lock", {30'd0, bus_latch_n, bus_lock_drive}, 32'd2);
      if (i == lock_hold - 1) other_lock = 1'b0;
      @(negedge clk);
    end
    phases = (op == 2'd2) ? 2 : 1;
    pend = 1'b0;
    pend_last = 1'b0;
    pend_data = '0;
    for (int ph = 0; ph < phases; ph++) begin
      is_w = (op == 2'd1) || (op == 2'd2 && ph == 1);
      chk(bus_latch_n == 1'b0, "R1 latch low in addr", {31'd0, bus_latch_n}, 32'd0);
      chk(bus_stat_n == 1'b0, "R1 status low in addr", {31'd0, bus_stat_n}, 32'd0);
      chk(bus_den_n == 1'b1, "R6 no data enable in addr", {31'd0, bus_den_n}, 32'd1);
      chk(bus_ad_oe && bus_ad_o == {addr, len}, "R1 addr and size code",
          bus_ad_o, {addr, len});
      chk(bus_wr == is_w && bus_dir == is_w, "R5 wr/dir set in addr",
          {30'd0, bus_wr, bus_dir}, {30'd0, is_w, is_w});
      if (op == 2'd2)
        chk(bus_lock_drive == (ph == 0), "R10 lock pull per phase",
            {31'd0, bus_lock_drive}, {31'd0, ph == 0});
      @(negedge clk);
      first = 1'b1;
      prev_rdy = 1'b0;
      for (int k = 0; k <= int'(len); k++) begin
        ix = widx(addr, k);
        do begin
          if (pend)
            chk(rd_valid && rd_data == pend_data && rd_last == pend_last,
                "R8 read return", rd_data, pend_data);
          else
            chk(rd_valid == 1'b0, "R8 no spurious return", {31'd0, rd_valid}, 32'd0);
          pend = 1'b0;
          chk(bus_den_n == 1'b0, "R6 data enable in data", {31'd0, bus_den_n}, 32'd0);
          chk(bus_latch_n == 1'b1, "R2 latch high in data", {31'd0, bus_latch_n}, 32'd1);
          if (first)
            chk(bus_stat_n == 1'b1, "R3 status high first data",
                {31'd0, bus_stat_n}, 32'd1);
          else if (prev_rdy)
            chk(bus_stat_n == 1'b0, "R3 status reissued",
                {31'd0, bus_stat_n}, 32'd0);
          else
            chk(bus_stat_n == 1'b1, "R4 status high after wait",
                {31'd0, bus_stat_n}, 32'd1);
          chk(bus_wr == is_w && bus_dir == is_w, "R5 wr/dir held",
              {30'd0, bus_wr, bus_dir}, {30'd0, is_w, is_w});
          if (is_w) begin
            chk(bus_ad_oe && bus_ad_o == w[k], "R7 write word on bus", bus_ad_o, w[k]);
          end else begin
            chk(bus_ad_oe == 1'b0, "R7 read floats bus", {31'd0, bus_ad_oe}, 32'd0);
            bus_ad_i = mem[ix];
          end
          r = (rmode == 1) ? 1'b1 : (($urandom % 3) != 0);
          bus_rdy = r;
          if (r) begin
            if (is_w) mem[ix] = w[k];
            else begin
              pend = 1'b1;
              pend_data = mem[ix];
              pend_last = (k == int'(len));
            end
          end
          @(negedge clk);
          first = 1'b0;
          prev_rdy = r;
        end while (!r);
      end
      bus_rdy = 1'b0;
      bus_ad_i = $urandom;
      if (pend)
        chk(rd_valid && rd_data == pend_data && rd_last == pend_last,
            "R8 final read return", rd_data, pend_data);
      pend = 1'b0;
    end
    chk(bus_den_n && bus_latch_n && !bus_ad_oe, "R9 burst ends idle",
        {29'd0, bus_den_n, bus_latch_n, bus_ad_oe}, 32'd6);
    chk(bus_lock_drive == 1'b0, "R10 lock released at end",
        {31'd0, bus_lock_drive}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    chk_idle_bus("R12 in reset");
    rst = 1'b0;
    @(negedge clk);
    chk_idle_bus("R12 after reset");
    chk(rd_valid == 1'b0, "R12 no read return", {31'd0, rd_valid}, 32'd0);

    // directed corners
    run_txn(2'd0, 30'h0000_0010, 2'd0, 0, 1);  // single-word read
    run_txn(2'd1, 30'h0000_0020, 2'd0, 0, 1);  // single-word write
    run_txn(2'd1, 30'h0000_0004, 2'd3, 0, 1);  // four words, no waits
    run_txn(2'd0, 30'h0000_0004, 2'd3, 0, 0);  // read back with waits
    run_txn(2'd2, 30'h0000_0008, 2'd1, 0, 0);  // rmw, line free
    run_txn(2'd2, 30'h0000_0030, 2'd2, 4, 0);  // rmw held off
    run_txn(2'd3, 30'h0000_0008, 2'd1, 0, 0);  // code 3 acts as read

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [1:0] op;
      op = 2'($urandom % 4);
      run_txn(op, 30'($urandom), 2'($urandom), ((op == 2'd2) && ($urandom % 2 == 1)) ? 2 : 0, 0);
      if ($urandom % 3 == 0) @(negedge clk);
    end

    // reset in the middle of a stalled write burst
    req_valid = 1'b1;
    req_op    = 2'd1;
    req_addr  = 30'h15;
    req_len   = 2'd3;
    req_wdata = {4{32'hA5A5_5A5A}};
    @(negedge clk);
    req_valid = 1'b0;
    bus_rdy   = 1'b0;
    repeat (3) @(negedge clk);
    chk(bus_den_n == 1'b0 && bus_ad_oe, "R4 stalled write keeps driving",
        {30'd0, bus_den_n, bus_ad_oe}, 32'd1);
    rst = 1'b1;
    @(negedge clk);
    chk_idle_bus("R12 reset mid-burst");
    rst = 1'b0;
    @(negedge clk);
    chk_idle_bus("R12 idle after mid-burst reset");
    chk(req_ready == 1'b1, "R11 ready after reset", {31'd0, req_ready}, 32'd1);
    run_txn(2'd0, 30'h15, 2'd1, 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule